// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the interrupt and fault requests of a 16-bit processor and gives the core one request at a time. Every maskable source has a latched request flag, an enable bit and a 3-bit priority. Every trap source has a pending bit and a fixed level above the maskable range. Each cycle the controller picks the pending request with the highest level and drives it to the core together with its vector address. A request is taken only if its level is strictly above the current 4-bit CPU level. The vector comes from the primary or the alternate table, as a control bit selects.

The core pulses `ack` when it takes the request shown. The controller then saves the old CPU level on a small internal stack and raises the level to the priority just taken. A `ret` pulse pops the saved level back. Software can turn on a no-nesting mode, which holds off maskable requests while any service is in progress and freezes the level field. Software can also open a counted window that holds off every maskable priority of 6 and below for a set number of retired instructions. A normal fetch that lands in vector space raises the address-error trap.

Register map (`reg_addr`): 0 is the flags, where a 1 written clears a bit. 1 is the enables. 2 is control: bit 0 no-nesting, bit 1 alternate table, bits 7:4 CPU level, bit 8 window active (read-only). 3 is the window count. 8+k is the priority of maskable source k.

Top module: `prio_vic`

## Requirements
- R1: An `irq_evt[k]` pulse sets flag k whatever its enable bit holds. A flag clears only when a 1 is written to bit k of register 0. A 0 written leaves it set, and a new event in the same cycle as a clear wins.
- R2: Maskable source k is shown only when its flag and enable bit are both set, its priority is not 0, and its priority is strictly above the CPU level.
- R3: The shown request has the highest level among eligible sources. When two levels are equal, the lower source index wins.
- R4: `req_vector` = base + 2*index. The base is 0x000004, or 0x000084 when control bit 1 is set. Trap i has index i, and maskable source k has index 4+k.
- R5: A `trap_req[i]` pulse latches trap i pending at level 15-i. Enable bits and the disable window have no effect on traps. Trap i clears when it is acknowledged.
- R6: `ack` while a request is shown pushes the CPU level and sets it to `req_level`. `ret` pops the most recently saved level.
- R7: When control bit 0 is set and a service is active, no maskable request is shown, even one above the CPU level. While bit 0 is set, writes to the level field are ignored.
- R8: Writing N to register 3 holds off maskable priorities 1 to 6 until N `retire` strobes have occurred. Control bit 8 reads 1 through the window. Priority 7 is not held off.
- R9: A `fetch_valid` fetch whose address lies in 0x000004..0x0000FE sets trap 1 (address error) pending. A fetch outside that range does not.
- R10: After reset all flags, enables, traps and the window are 0, the CPU level is 0, every priority is 4, and no request is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_evt | input | 21 | Maskable source event pulses |
| trap_req | input | 4 | Trap request pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_valid | input | 1 | Normal instruction fetch in progress |
| fetch_addr | input | 24 | Fetch address |
| retire | input | 1 | Instruction retired strobe |
| ack | input | 1 | Core accepts the shown request |
| ret | input | 1 | Core returns from service |
| req_valid | output | 1 | A request is shown |
| req_vector | output | 24 | Vector address of the shown request |
| req_level | output | 4 | Level of the shown request |
| cpu_level | output | 4 | Current CPU priority level |

## Verification
Arbitration is tried with two maskable sources at different priorities, then at equal priority, then with one priority set to 0, and then against CPU levels just at and just below the winner. These cases separate a strict level compare from a non-strict one, and the index tie-break from a last-wins tie-break. Nested acknowledges with returns show that the saved levels come back in stack order. No-nesting is tried with a trap arriving in the middle, which separates maskable blocking from trap blocking. The window is tried with a priority-7 source arriving during it, and the request that was held off is counted out to the exact retire strobe that releases it.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int REG_FLAG  = 0;
    localparam int REG_EN    = 1;
    localparam int REG_CTRL  = 2;
    localparam int REG_WIN   = 3;
    localparam int PRIO_BASE = 8;
    localparam int CTRL_LVL_LSB = 4;
    localparam int CTRL_WIN_BIT = 8;
endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NUM_IRQ  = 21,
    parameter int NUM_TRAP = 4,
    parameter int PRIO_W   = 3,
    parameter int LVL_W    = 4,
    parameter int IDX_W    = 5
) (
    input  logic [NUM_IRQ-1:0]              flags,
    input  logic [NUM_IRQ-1:0]              enables,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prios,
    input  logic [NUM_TRAP-1:0]             traps,
    input  logic [LVL_W-1:0]                cur_lvl,
    input  logic                            hold_low,
    input  logic                            hold_mask,
    output logic                            win_valid,
    output logic [IDX_W-1:0]                win_idx,
    output logic [LVL_W-1:0]                win_lvl
);
    localparam int LVL_TOP = (1 << LVL_W) - 1;
    localparam int LOW_MAX = (1 << PRIO_W) - 2;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        // strict '>' against the best so far keeps the lower index on ties
        for (int i = 0; i < NUM_TRAP; i++) begin
            if (traps[i] && (LVL_W'(LVL_TOP - i) > cur_lvl)
                && (LVL_W'(LVL_TOP - i) > win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = LVL_W'(LVL_TOP - i);
            end
        end
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (flags[k] && enables[k] && (prios[k] != '0) && !hold_mask
                && !(hold_low && (int'(prios[k]) <= LOW_MAX))
                && (LVL_W'(prios[k]) > cur_lvl) && (LVL_W'(prios[k]) > win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(NUM_TRAP + k);
                win_lvl   = LVL_W'(prios[k]);
            end
        end
    end
endmodule

// File: rtl/vic_vecgen.sv
module vic_vecgen #(
    parameter int ADDR_W  = 24,
    parameter int IDX_W   = 5,
    parameter int VEC_LO  = 'h4,
    parameter int VEC_HI  = 'hFE,
    parameter int ALT_OFS = 'h80
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              alt,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] vector,
    output logic              fetch_hit
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base      = alt ? ADDR_W'(VEC_LO + ALT_OFS) : ADDR_W'(VEC_LO);
        vector    = base + ADDR_W'({idx, 1'b0});
        fetch_hit = fetch_valid && (fetch_addr >= ADDR_W'(VEC_LO))
                    && (fetch_addr <= ADDR_W'(VEC_HI));
    end
endmodule

// File: rtl/prio_vic.sv
module prio_vic #(
    parameter int NUM_IRQ      = 21,
    parameter int NUM_TRAP     = 4,
    parameter int PRIO_W       = 3,
    parameter int LVL_W        = 4,
    parameter int CNT_W        = 14,
    parameter int ADDR_W       = 24,
    parameter int DATA_W       = 32,
    parameter int STACK_D      = 16,
    parameter int ADDRERR_TRAP = 1,
    localparam int REG_AW      = $clog2(vic_pkg::PRIO_BASE + NUM_IRQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_evt,
    input  logic [NUM_TRAP-1:0] trap_req,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                fetch_valid,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic                retire,
    input  logic                ack,
    input  logic                ret,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_vector,
    output logic [LVL_W-1:0]    req_level,
    output logic [LVL_W-1:0]    cpu_level
);
    import vic_pkg::*;

    localparam int NSRC  = NUM_TRAP + NUM_IRQ;
    localparam int IDX_W = $clog2(NSRC);
    localparam int DEP_W = $clog2(STACK_D + 1);

    typedef struct packed {
        logic [NUM_IRQ-1:0]             flag;
        logic [NUM_IRQ-1:0]             en;
        logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
        logic [NUM_TRAP-1:0]            trap;
        logic [LVL_W-1:0]               lvl;
        logic                           nonest;
        logic                           alt;
        logic [CNT_W-1:0]               win;
        logic [STACK_D-1:0][LVL_W-1:0]  stk;
        logic [DEP_W-1:0]               dep;
    } st_t;

    st_t st_d, st_q;

    logic             win_valid, fetch_hit;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic             take;

    vic_arbiter #(
        .NUM_IRQ(NUM_IRQ), .NUM_TRAP(NUM_TRAP), .PRIO_W(PRIO_W),
        .LVL_W(LVL_W), .IDX_W(IDX_W)
    ) u_arb (
        .flags(st_q.flag), .enables(st_q.en), .prios(st_q.prio),
        .traps(st_q.trap), .cur_lvl(st_q.lvl),
        .hold_low(st_q.win != '0),
        .hold_mask(st_q.nonest && (st_q.dep != '0)),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    vic_vecgen #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_vec (
        .idx(win_idx), .alt(st_q.alt), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .vector(req_vector), .fetch_hit(fetch_hit)
    );

    assign req_valid = win_valid;
    assign req_level = win_lvl;
    assign cpu_level = st_q.lvl;
    assign take      = ack && win_valid && (st_q.dep < DEP_W'(STACK_D));

    always_comb begin
        st_d = st_q;

        // flags: clear by writing 1, new events win
        if (reg_we && reg_addr == REG_AW'(REG_FLAG))
            st_d.flag = st_q.flag & ~reg_wdata[NUM_IRQ-1:0];
        st_d.flag = st_d.flag | irq_evt;

        if (reg_we && reg_addr == REG_AW'(REG_EN))
            st_d.en = reg_wdata[NUM_IRQ-1:0];

        for (int k = 0; k < NUM_IRQ; k++)
            if (reg_we && reg_addr == REG_AW'(PRIO_BASE + k))
                st_d.prio[k] = reg_wdata[PRIO_W-1:0];

        if (reg_we && reg_addr == REG_AW'(REG_CTRL)) begin
            st_d.nonest = reg_wdata[0];
            st_d.alt    = reg_wdata[1];
            if (!st_q.nonest)
                st_d.lvl = reg_wdata[CTRL_LVL_LSB +: LVL_W];
        end

        if (reg_we && reg_addr == REG_AW'(REG_WIN))
            st_d.win = reg_wdata[CNT_W-1:0];
        else if (retire && st_q.win != '0)
            st_d.win = st_q.win - 1'b1;

        // level stack: accept wins over return in the same cycle
        if (take) begin
            st_d.stk[st_q.dep[DEP_W-2:0]] = st_q.lvl;
            st_d.dep = st_q.dep + 1'b1;
            st_d.lvl = win_lvl;
            if (int'(win_idx) < NUM_TRAP)
                st_d.trap[win_idx[$clog2(NUM_TRAP)-1:0]] = 1'b0;
        end else if (ret && st_q.dep != '0) begin
            st_d.dep = st_q.dep - 1'b1;
            st_d.lvl = st_q.stk[st_d.dep[DEP_W-2:0]];
        end

        st_d.trap = st_d.trap | trap_req;
        if (fetch_hit)
            st_d.trap[ADDRERR_TRAP] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int k = 0; k < NUM_IRQ; k++)
                st_q.prio[k] <= PRIO_W'(1 << (PRIO_W - 1));
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            REG_FLAG: reg_rdata = DATA_W'(st_q.flag);
            REG_EN:   reg_rdata = DATA_W'(st_q.en);
            REG_CTRL: begin
                reg_rdata[0] = st_q.nonest;
                reg_rdata[1] = st_q.alt;
                reg_rdata[CTRL_LVL_LSB +: LVL_W] = st_q.lvl;
                reg_rdata[CTRL_WIN_BIT] = (st_q.win != '0);
            end
            REG_WIN:  reg_rdata = DATA_W'(st_q.win);
            default: begin
                for (int k = 0; k < NUM_IRQ; k++)
                    if (int'(reg_addr) == PRIO_BASE + k)
                        reg_rdata = DATA_W'(st_q.prio[k]);
            end
        endcase
    end
endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk #(
    parameter int NUM_IRQ = 21,
    parameter int LVL_W   = 4,
    parameter int ADDR_W  = 24,
    parameter int CNT_W   = 14,
    parameter int DEP_W   = 5,
    parameter int STACK_D = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_IRQ-1:0]  irq_evt,
    input logic [NUM_IRQ-1:0]  flag,
    input logic                ack,
    input logic                ret,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_vector,
    input logic [LVL_W-1:0]    req_level,
    input logic [LVL_W-1:0]    cpu_level,
    input logic                nonest,
    input logic [CNT_W-1:0]    win,
    input logic [DEP_W-1:0]    dep
);
    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt != '0) |=> ((flag & $past(irq_evt)) == $past(irq_evt)));

    // R2
    above_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_level > cpu_level));

    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (!req_vector[0] && req_vector >= ADDR_W'('h4) && req_vector <= ADDR_W'('hFE)));

    // R6
    ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_valid && dep < DEP_W'(STACK_D)) |=> (cpu_level == $past(req_level)));

    // R6
    ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !ack && dep != '0) |=> (dep == $past(dep) - 1'b1));

    // R7
    no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nonest && dep != '0 && req_valid) |-> req_level[LVL_W-1]);

    // R8
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win != '0 && req_valid) |-> (req_level >= LVL_W'(7)));
endmodule

bind prio_vic prio_vic_chk #(
    .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .DEP_W($clog2(STACK_D + 1)), .STACK_D(STACK_D)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .flag(st_q.flag),
    .ack(ack), .ret(ret), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .cpu_level(cpu_level), .nonest(st_q.nonest),
    .win(st_q.win), .dep(st_q.dep)
);

// File: tb/prio_vic_bench.sv
module prio_vic_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [20:0] irq_evt = '0;
    logic [3:0]  trap_req = '0;
    logic        reg_we = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 0;
    logic [23:0] fetch_addr = '0;
    logic        retire = 0, ack = 0, ret = 0;
    logic        req_valid;
    logic [23:0] req_vector;
    logic [3:0]  req_level, cpu_level;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prio_vic u_prio_vic (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .trap_req(trap_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .retire(retire), .ack(ack), .ret(ret), .req_valid(req_valid),
        .req_vector(req_vector), .req_level(req_level), .cpu_level(cpu_level)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk); reg_addr = 5'(a); #1; d = reg_rdata;
    endtask

    task automatic evt(int k);
        @(negedge clk); irq_evt = 21'(1) << k;
        @(negedge clk); irq_evt = '0;
    endtask

    task automatic trap(int i);
        @(negedge clk); trap_req = 4'(1) << i;
        @(negedge clk); trap_req = '0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); ret = 1; @(negedge clk); ret = 0;
    endtask

    task automatic pulse_retire();
        @(negedge clk); retire = 1; @(negedge clk); retire = 0;
    endtask

    task automatic cleanup();
        wr(0, 32'h1FFFFF); wr(1, 0); wr(2, 0); wr(2, 0); wr(3, 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, d); check("R10 flags", d, 0);
        rd(1, d); check("R10 enables", d, 0);
        rd(8, d); check("R10 prio0", d, 4);
        check("R10 req_valid", 32'(req_valid), 0);
        check("R10 cpu_level", 32'(cpu_level), 0);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        evt(3);
        rd(0, d); check("R1 flag set while disabled", d, 32'h8);
        check("R2 disabled not shown", 32'(req_valid), 0);
        wr(0, 0);
        rd(0, d); check("R1 zero write keeps flag", d, 32'h8);
        wr(0, 32'h8);
        rd(0, d); check("R1 one write clears", d, 0);
        evt(3);
        @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 32'h8; irq_evt = 21'h8;
        @(negedge clk); reg_we = 0; irq_evt = 0;
        rd(0, d); check("R1 event beats clear", d, 32'h8);
        cleanup();
    endtask

    task automatic t_arb();
        wr(1, 32'h24); wr(8+2, 3); wr(8+5, 5);
        evt(2); evt(5);
        check("R3 higher prio wins", 32'(req_level), 5);
        check("R4 vector src5", 32'(req_vector), 32'h16);
        wr(8+2, 5);
        check("R3 tie lower index", 32'(req_vector), 32'h10);
        wr(8+2, 0);
        check("R2 prio zero skipped", 32'(req_vector), 32'h16);
        wr(2, 32'h50);
        check("R2 equal level blocked", 32'(req_valid), 0);
        wr(2, 32'h40);
        check("R2 above level shown", 32'(req_valid), 1);
        wr(2, 32'h02);
        check("R4 alternate table", 32'(req_vector), 32'h96);
        cleanup();
    endtask

    task automatic t_nest();
        wr(1, 32'hA4); wr(8+2, 3); wr(8+5, 6); wr(8+7, 7);
        evt(2); evt(5);
        pulse_ack();
        check("R6 level raised", 32'(cpu_level), 6);
        check("R6 lower not shown", 32'(req_valid), 0);
        evt(7);
        check("R6 nested level7 shown", 32'(req_level), 7);
        pulse_ack();
        check("R6 level 7", 32'(cpu_level), 7);
        pulse_ret();
        check("R6 pop to 6", 32'(cpu_level), 6);
        pulse_ret();
        check("R6 pop to 0", 32'(cpu_level), 0);
        cleanup();
    endtask

    task automatic t_nonest();
        logic [31:0] d;
        wr(1, 32'h84); wr(8+2, 3); wr(8+7, 7);
        evt(2);
        pulse_ack();
        wr(2, 32'h31);
        evt(7);
        check("R7 maskable held off", 32'(req_valid), 0);
        wr(2, 32'h01);
        rd(2, d); check("R7 level field frozen", (d >> 4) & 32'hF, 3);
        trap(3);
        check("R5 trap during no-nest", 32'(req_level), 12);
        check("R4 trap3 vector", 32'(req_vector), 32'hA);
        pulse_ack();
        check("R5 trap level taken", 32'(cpu_level), 12);
        pulse_ret();
        check("R7 still held at depth1", 32'(req_valid), 0);
        pulse_ret();
        check("R7 released at depth0", 32'(req_level), 7);
        cleanup();
    endtask

    task automatic t_window();
        logic [31:0] d;
        wr(1, 32'h84); wr(8+2, 6); wr(8+7, 7);
        evt(2);
        check("R8 before window", 32'(req_level), 6);
        wr(3, 3);
        check("R8 prio6 held", 32'(req_valid), 0);
        rd(2, d); check("R8 status set", (d >> 8) & 1, 1);
        evt(7);
        check("R8 prio7 passes", 32'(req_vector), 32'h1A);
        wr(0, 32'h80);
        pulse_retire(); pulse_retire();
        check("R8 held after 2", 32'(req_valid), 0);
        pulse_retire();
        check("R8 released after 3", 32'(req_vector), 32'h10);
        rd(2, d); check("R8 status clear", (d >> 8) & 1, 0);
        cleanup();
    endtask

    task automatic t_traps();
        trap(2);
        check("R5 trap2 level", 32'(req_level), 13);
        check("R5 trap2 vector", 32'(req_vector), 32'h8);
        trap(0);
        check("R5 trap0 wins", 32'(req_vector), 32'h4);
        pulse_ack();
        check("R5 trap0 level", 32'(cpu_level), 15);
        pulse_ret();
        check("R5 trap2 remains", 32'(req_level), 13);
        pulse_ack(); pulse_ret();
        check("R5 all traps cleared", 32'(req_valid), 0);
    endtask

    task automatic fetch(logic [23:0] a);
        @(negedge clk); fetch_valid = 1; fetch_addr = a;
        @(negedge clk); fetch_valid = 0;
    endtask

    task automatic t_fetch();
        fetch(24'h000100);
        check("R9 outside above", 32'(req_valid), 0);
        fetch(24'h000002);
        check("R9 outside below", 32'(req_valid), 0);
        fetch(24'h0000FE);
        check("R9 addr error level", 32'(req_level), 14);
        check("R9 addr error vector", 32'(req_vector), 32'h6);
        pulse_ack(); pulse_ret();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_flags();
        t_arb();
        t_nest();
        t_nonest();
        t_window();
        t_traps();
        t_fetch();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule